// File: doc/BRIEF.md
# Polled Tamper Event Counter

This block counts transitions on an external event pin that has already been synchronised to the system clock. It has two detection styles.

In continuous detection the pin is sampled on every pulse of a slow clock enable, which is derived from the 32.768 kHz real-time oscillator. Either the rising or the falling transition is counted, as programmed.

For tamper sensing on battery power, a polled mode duty-cycles the pin. A divider counts oscillator ticks. Near the end of each poll period the divider raises a pull-up enable for a short settle window. On the last tick of that window it takes one sample of the pin. A normally closed switch holds the pin low. When the case is opened, the pull-up wins and the sample goes high. A low sample followed by a high sample counts as one tamper event.

Polling is allowed only in the battery-backed retention setting, and it always uses rising-edge detection. The poll timer runs only while the oscillator is enabled. The event count can be read at any time and can be cleared synchronously.

Top module: `tamper_event_counter`

## Requirements
- R1: After reset, `count` is 0 and `pullup_en` is low.
- R2: In polled mode the poll period is POLL_DIV oscillator ticks (default 4096, which gives 125 ms at 32.768 kHz). `pullup_en` is high while the divider is in its last SETTLE counts (default 4) of each period, and low for the rest of the period.
- R3: In polled mode the pin is sampled on the final tick of each pull-up window. `count` increments when the previous poll sample was 0 and the current sample is 1. `edge_rising` has no effect in polled mode.
- R4: The first sample taken after the detection style changes (polled to continuous, or continuous to polled) only records the pin level and never counts.
- R5: Polled mode is active only when `poll_mode`=1 and `retain_nv`=0. When `retain_nv`=1, `poll_mode` is ignored, continuous detection is used and `pullup_en` stays low.
- R6: When `osc_en`=0 the poll timer is held at zero. While it is held, `pullup_en` is low and no poll samples are taken. When `osc_en` returns to 1, a full period runs before the next poll sample.
- R7: In continuous mode the pin is sampled on each `osc_tick` pulse and at no other time. With `edge_rising`=1, a 0-to-1 change between successive samples counts. With `edge_rising`=0, a 1-to-0 change counts.
- R8: `count` is CNT_W bits wide (default 16) and wraps from all ones to zero.
- R9: A `clr_cnt` pulse sets `count` to 0 on the next clock edge and overrides an increment in the same cycle.
- R10: `count` changes by at most one per clock. The change appears on the clock edge that takes the qualifying sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the oscillator rate |
| osc_en | input | 1 | Oscillator running; gates the poll timer |
| pin_in | input | 1 | Synchronised event pin level |
| poll_mode | input | 1 | Request polled tamper mode |
| edge_rising | input | 1 | Continuous mode polarity: 1 counts rising transitions, 0 counts falling transitions |
| retain_nv | input | 1 | Retention select: 1 = nonvolatile, 0 = battery-backed |
| clr_cnt | input | 1 | Synchronous clear of the count |
| pullup_en | output | 1 | Enables the weak pin pull-up during a poll window |
| count | output | CNT_W | Event count |

## Verification
A wrong divider state shows up at `pullup_en`. The window moves, lengthens or shortens within one poll period, so a per-clock comparison catches it within POLL_DIV ticks.

A stale previous sample or validity flag shows up as a count one too high or one too low. This appears on the clock edge after the first sample taken in the new mode.

Counter faults, such as a wrong wrap or a clear losing to an increment, show on `count` on the very next edge.

// File: rtl/tec_pkg.sv
package tec_pkg;

    typedef enum logic {
        DET_CONT = 1'b0,
        DET_POLL = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic prev;
        logic valid;
    } samp_st_t;

endpackage

// File: rtl/tec_poll_timer.sv
module tec_poll_timer #(
    parameter int POLL_DIV = 4096,
    parameter int SETTLE   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic pullup_en,
    output logic sample_stb
);
    localparam int DW = (POLL_DIV > 1) ? $clog2(POLL_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(POLL_DIV - 1);
    localparam logic [DW-1:0] OPEN = DW'(POLL_DIV - SETTLE);

    typedef struct packed {
        logic [DW-1:0] div;
    } tmr_t;

    tmr_t st_d, st_q;
    logic stb_d;

    always_comb begin
        st_d  = st_q;
        stb_d = 1'b0;
        if (!run) begin
            st_d.div = '0;
        end else if (tick) begin
            if (st_q.div == LAST) begin
                st_d.div = '0;
                stb_d    = 1'b1;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pullup_en  = run && (st_q.div >= OPEN);
    assign sample_stb = stb_d;

endmodule

// File: rtl/tec_edge_det.sv
module tec_edge_det
    import tec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic stb,
    input  logic bit_in,
    input  logic rise_sel,
    output logic hit
);
    samp_st_t st_d, st_q;
    logic     hit_d;

    always_comb begin
        st_d  = st_q;
        hit_d = 1'b0;
        if (stb && st_q.valid && !restart) begin
            if (rise_sel) begin
                hit_d = !st_q.prev && bit_in;
            end else begin
                hit_d = st_q.prev && !bit_in;
            end
        end
        if (restart) begin
            st_d.valid = 1'b0;
        end else if (stb) begin
            st_d.valid = 1'b1;
            st_d.prev  = bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit = hit_d;

endmodule

// File: rtl/tec_event_cnt.sv
module tec_event_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q;

endmodule

// File: rtl/tamper_event_counter.sv
module tamper_event_counter
    import tec_pkg::*;
#(
    parameter int POLL_DIV = 4096,
    parameter int SETTLE   = 4,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             osc_en,
    input  logic             pin_in,
    input  logic             poll_mode,
    input  logic             edge_rising,
    input  logic             retain_nv,
    input  logic             clr_cnt,
    output logic             pullup_en,
    output logic [CNT_W-1:0] count
);
    det_mode_e mode_d, mode_q;
    logic      restart;
    logic      poll_stb;
    logic      stb;
    logic      rise_sel;
    logic      hit;

    always_comb begin
        mode_d   = (poll_mode && !retain_nv) ? DET_POLL : DET_CONT;
        restart  = (mode_d != mode_q);
        stb      = (mode_d == DET_POLL) ? poll_stb : osc_tick;
        rise_sel = (mode_d == DET_POLL) || edge_rising;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= DET_CONT;
        end else begin
            mode_q <= mode_d;
        end
    end

    tec_poll_timer #(
        .POLL_DIV(POLL_DIV),
        .SETTLE  (SETTLE)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       ((mode_d == DET_POLL) && osc_en),
        .tick      (osc_tick),
        .pullup_en (pullup_en),
        .sample_stb(poll_stb)
    );

    tec_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .stb     (stb),
        .bit_in  (pin_in),
        .rise_sel(rise_sel),
        .hit     (hit)
    );

    tec_event_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_cnt),
        .inc  (hit),
        .value(count)
    );

endmodule

// File: rtl/tec_checker.sv
module tec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic             poll_mode,
    input logic             retain_nv,
    input logic             clr_cnt,
    input logic             pullup_en,
    input logic [CNT_W-1:0] count
);
    // R9
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (count == '0));

    // R10
    a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cnt |=> ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1))));

    // R6
    a_r6_osc_off_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !pullup_en);

    // R5
    a_r5_no_poll_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
        (retain_nv || !poll_mode) |-> !pullup_en);

    // R3
    a_r3_poll_counts_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_mode && !retain_nv && !clr_cnt && !pullup_en) |=> $stable(count));

endmodule

bind tamper_event_counter tec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .poll_mode(poll_mode),
    .retain_nv(retain_nv),
    .clr_cnt  (clr_cnt),
    .pullup_en(pullup_en),
    .count    (count)
);

// File: tb/tb_tamper_event_counter.sv
`timescale 1ns/1ps
module tb_tamper_event_counter;
    localparam int P  = 16;
    localparam int S  = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0, osc_en = 1'b1, pin_in = 1'b0;
    logic poll_mode = 1'b0, edge_rising = 1'b1, retain_nv = 1'b0, clr_cnt = 1'b0;
    logic pullup_en;
    logic [CW-1:0] count;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    tamper_event_counter #(.POLL_DIV(P), .SETTLE(S), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .osc_en(osc_en),
        .pin_in(pin_in), .poll_mode(poll_mode), .edge_rising(edge_rising),
        .retain_nv(retain_nv), .clr_cnt(clr_cnt), .pullup_en(pullup_en),
        .count(count)
    );

    // Behavioural reference
    int m_div = 0, m_cnt = 0;
    bit m_prev = 0, m_valid = 0, m_act_q = 0;

    always @(posedge clk) begin
        bit act, stb, hit, rise;
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_prev = 0; m_valid = 0; m_act_q = 0;
        end else begin
            act = poll_mode && !retain_nv;
            stb = 0;
            if (act) begin
                if (!osc_en) m_div = 0;
                else if (osc_tick) begin
                    if (m_div == P - 1) begin stb = 1; m_div = 0; end
                    else m_div++;
                end
            end else begin
                m_div = 0;
                stb = osc_tick;
            end
            rise = act || edge_rising;
            hit = stb && m_valid && (act == m_act_q) &&
                  (rise ? (!m_prev && pin_in) : (m_prev && !pin_in));
            if (act != m_act_q) m_valid = 0;
            else if (stb) begin m_valid = 1; m_prev = pin_in; end
            if (clr_cnt) m_cnt = 0;
            else if (hit) m_cnt = (m_cnt + 1) % (1 << CW);
            m_act_q = act;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        bit exp_pu;
        @(posedge clk);
        @(negedge clk);
        exp_pu = poll_mode && !retain_nv && osc_en && (m_div >= P - S);
        chk(int'(count) == m_cnt, "R10 count vs model", int'(count), m_cnt);
        chk(pullup_en == exp_pu, "R2 pullup_en vs model", int'(pullup_en), int'(exp_pu));
    endtask

    task automatic clear();
        clr_cnt = 1; osc_tick = 0;
        step();
        clr_cnt = 0;
    endtask

    task automatic poll_once(input bit b, output int hi);
        hi = 0;
        pin_in = b; osc_tick = 1;
        for (int i = 0; i < P; i++) begin
            step();
            if (pullup_en) hi++;
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        int hi;
        int base;
        bit seq [8] = '{0, 1, 1, 0, 1, 0, 0, 1};
        bit pb  [6] = '{1, 0, 1, 1, 0, 1};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(count == 0, "R1 reset count", int'(count), 0);
        chk(pullup_en == 0, "R1 reset pullup", int'(pullup_en), 0);

        // R7 continuous rising
        osc_tick = 1; pin_in = 0;
        repeat (3) step();
        clear();
        osc_tick = 1;
        foreach (seq[i]) begin pin_in = seq[i]; step(); end
        chk(count == 3, "R7 rising count", int'(count), 3);

        // R7 falling
        clear();
        edge_rising = 0; osc_tick = 1;
        foreach (seq[i]) begin pin_in = seq[i]; step(); end
        chk(count == 3, "R7 falling count", int'(count), 3);

        // R7 no sampling without osc_tick
        edge_rising = 1; osc_tick = 0;
        base = int'(count);
        repeat (4) begin pin_in = ~pin_in; step(); end
        chk(int'(count) == base, "R7 no tick no count", int'(count), base);
        pin_in = 0; osc_tick = 1; step();

        // R4/R3/R2 polled mode with falling polarity requested
        clear();
        edge_rising = 0; poll_mode = 1;
        foreach (pb[i]) begin
            poll_once(pb[i], hi);
            chk(hi == S, "R2 pullup window length", hi, S);
            if (i == 0) chk(count == 0, "R4 first poll only initialises", int'(count), 0);
        end
        chk(count == 2, "R3 polled rising count", int'(count), 2);

        // R6 oscillator off
        osc_en = 0; osc_tick = 1; hi = 0;
        for (int i = 0; i < 40; i++) begin
            pin_in = i[1];
            step();
            if (pullup_en) hi++;
        end
        chk(hi == 0, "R6 no pullup with osc off", hi, 0);
        chk(count == 2, "R6 no count with osc off", int'(count), 2);
        osc_en = 1;
        poll_once(0, hi);
        poll_once(1, hi);
        chk(count == 3, "R6 polling resumes", int'(count), 3);

        // R5 nonvolatile retention blocks polling
        retain_nv = 1; edge_rising = 1; osc_tick = 1; pin_in = 1; hi = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (pullup_en) hi++;
        end
        chk(hi == 0, "R5 no pullup when retain_nv", hi, 0);
        base = int'(count);
        for (int i = 0; i < 4; i++) begin pin_in = i[0]; step(); end
        chk(int'(count) == base + 2, "R5 continuous detection used", int'(count), base + 2);
        poll_mode = 0; retain_nv = 0;
        pin_in = 0; step(); step();

        // R8 wrap
        clear();
        osc_tick = 1;
        for (int i = 0; i < 600; i++) begin pin_in = ~i[0]; step(); end
        chk(count == 44, "R8 wrap count", int'(count), 44);

        // R9 clear beats increment
        pin_in = 0; osc_tick = 1; step();
        pin_in = 1; clr_cnt = 1; step();
        clr_cnt = 0;
        chk(count == 0, "R9 clear overrides increment", int'(count), 0);
        step();
        chk(count == 0, "R9 no late increment", int'(count), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule